// File: doc/BRIEF.md
# Trigger Match Unit

This block watches a trigger bus of configurable width and raises a one-bit match event whenever the bus satisfies a condition set up at run time. It is one comparator of a debug capture engine. Several such units can share one trigger bus, and all units on one bus are built with the same comparison capabilities. Each bit of the bus is given its own pattern code. A code can ask for a fixed level, ignore the bit, or ask for a transition of that bit between the previous sample and the current one. A global operator then turns the per-bit results into equality, inequality, an unsigned magnitude test or a range test.

An occurrence counter can sit behind the comparator. When it is present, the unit raises its event only once the comparison has matched a programmed number of times since the last re-arm. After that the event follows every further match. A re-arm strobe clears the counter. The event output is registered, so it appears one clock after the trigger sample that caused it. The registers that hold the configuration are outside this block and drive its configuration inputs directly.

Top module: `trig_match_unit`

## Requirements
- R1: While reset is low the event output is 0. In the first clocked cycle after reset there is no previous sample, so every transition code (rise, fall, any) fails and the steady code passes.
- R2: Bit code 0 requires the bit to be 0 and code 1 requires it to be 1. Codes 2 and 7 ignore the bit. Operator 0 (equal) matches when every level bit has its required value and every edge bit's condition holds.
- R3: Bit code 3 requires a 0-to-1 change of the bit between the previous and the current sample. Code 4 requires a 1-to-0 change, code 5 requires any change and code 6 requires no change.
- R4: Operator 1 (not equal) gives exactly the inverse of operator 0 for the same inputs.
- R5: Operators 2, 3, 4 and 5 (greater, greater or equal, less, less or equal) compare the bus as an unsigned number against the reference formed by the level bits. Only bits with code 0 or 1 take part, all other bits count as 0 on both sides, and all edge bit conditions must also hold.
- R6: Operator 6 matches when the level-bit part of the bus lies between the lower and the upper bound, both ends included. Operator 7 matches when it lies outside. Both bounds are masked by the level bits, and both operators also require the edge bit conditions.
- R7: The event output is registered. A change of the inputs does not reach the output before the next rising clock edge, and the result of a sample is visible right after that edge.
- R8: With the counter present, a match raises the event only when the number of matches since re-arm, this one included, is at least the programmed target. A target of 0 acts as 1, and the count saturates at its maximum.
- R9: A re-arm strobe clears the match count and forces the event for that cycle to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rstN | input | 1 | Asynchronous reset, active low |
| trigIn | input | WIDTH | Trigger bus being watched |
| cfgBitMode | input | 3*WIDTH | Per-bit pattern codes, bit i uses bits [3i+2:3i] |
| cfgOp | input | 3 | Comparison operator code |
| cfgLow | input | WIDTH | Inclusive lower range bound |
| cfgHigh | input | WIDTH | Inclusive upper range bound |
| cfgCount | input | CNT_W | Number of matches needed before the event is raised |
| rearm | input | 1 | Clears the match count |
| matchEvent | output | 1 | Registered match event |

## Verification
Every result of this block is due exactly one rising edge after the sample that produced it. Edge codes look one further sample back, and the counter carries history from every match since the last re-arm. The bench drives all inputs just after a falling edge. Before the next rising edge it confirms that the output still shows the previous result, which covers the one-cycle latency. Half a period after that edge it compares the output with a value its model computed from the same inputs, the previous sample and the modelled match count.

// File: rtl/tmu_pkg.sv
package tmu_pkg;

  // Per-bit pattern codes
  typedef enum logic [2:0] {
    BM_LOW    = 3'd0,
    BM_HIGH   = 3'd1,
    BM_DC     = 3'd2,
    BM_RISE   = 3'd3,
    BM_FALL   = 3'd4,
    BM_ANY    = 3'd5,
    BM_STEADY = 3'd6,
    BM_DC2    = 3'd7
  } bit_mode_e;

  // Global comparison operator codes
  typedef enum logic [2:0] {
    OP_EQ      = 3'd0,
    OP_NE      = 3'd1,
    OP_GT      = 3'd2,
    OP_GE      = 3'd3,
    OP_LT      = 3'd4,
    OP_LE      = 3'd5,
    OP_INSIDE  = 3'd6,
    OP_OUTSIDE = 3'd7
  } cmp_op_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic edgeValid;   // a previous sample exists
    logic sampleEn;    // capture current sample as previous
  } tmu_strobe_t;

endpackage

// File: rtl/tmu_bit_decode.sv
module tmu_bit_decode
  import tmu_pkg::*;
(
  input  logic [2:0] modeIn,
  input  logic       curBit,
  input  logic       prevBit,
  input  logic       edgeValid,
  output logic       careBit,
  output logic       refBit,
  output logic       edgeOk
);

  bit_mode_e code;
  logic      changed;

  assign code    = bit_mode_e'(modeIn);
  assign changed = curBit ^ prevBit;

  always_comb begin
    careBit = 1'b0;
    refBit  = 1'b0;
    edgeOk  = 1'b1;
    unique case (code)
      BM_LOW:    careBit = 1'b1;
      BM_HIGH: begin
        careBit = 1'b1;
        refBit  = 1'b1;
      end
      BM_RISE:   edgeOk = edgeValid & ~prevBit & curBit;
      BM_FALL:   edgeOk = edgeValid & prevBit & ~curBit;
      BM_ANY:    edgeOk = edgeValid & changed;
      BM_STEADY: edgeOk = ~edgeValid | ~changed;
      default:   edgeOk = 1'b1;  // don't care codes
    endcase
  end

endmodule

// File: rtl/tmu_datapath.sv
module tmu_datapath
  import tmu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmu_strobe_t        strobe,
  input  logic [WIDTH-1:0]   trigIn,
  input  logic [3*WIDTH-1:0] cfgBitMode,
  input  logic [2:0]         cfgOp,
  input  logic [WIDTH-1:0]   cfgLow,
  input  logic [WIDTH-1:0]   cfgHigh,
  output logic               hit
);

  logic [WIDTH-1:0] prevQ;
  logic [WIDTH-1:0] careMask;
  logic [WIDTH-1:0] refVal;
  logic [WIDTH-1:0] edgeVec;
  logic [WIDTH-1:0] curMasked;
  logic [WIDTH-1:0] lowMasked;
  logic [WIDTH-1:0] highMasked;
  logic             edgesOk;
  logic             levelEq;
  logic             aboveRef;
  logic             belowRef;
  logic             inRange;
  cmp_op_e          op;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              prevQ <= '0;
    else if (strobe.sampleEn) prevQ <= trigIn;
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    tmu_bit_decode u_dec (
      .modeIn    (cfgBitMode[3*g +: 3]),
      .curBit    (trigIn[g]),
      .prevBit   (prevQ[g]),
      .edgeValid (strobe.edgeValid),
      .careBit   (careMask[g]),
      .refBit    (refVal[g]),
      .edgeOk    (edgeVec[g])
    );
  end

  assign curMasked  = trigIn  & careMask;
  assign lowMasked  = cfgLow  & careMask;
  assign highMasked = cfgHigh & careMask;
  assign edgesOk    = &edgeVec;
  assign levelEq    = (curMasked == refVal);
  assign aboveRef   = (curMasked >  refVal);
  assign belowRef   = (curMasked <  refVal);
  assign inRange    = (curMasked >= lowMasked) && (curMasked <= highMasked);
  assign op         = cmp_op_e'(cfgOp);

  always_comb begin
    unique case (op)
      OP_EQ:      hit = edgesOk & levelEq;
      OP_NE:      hit = ~(edgesOk & levelEq);
      OP_GT:      hit = edgesOk & aboveRef;
      OP_GE:      hit = edgesOk & ~belowRef;
      OP_LT:      hit = edgesOk & belowRef;
      OP_LE:      hit = edgesOk & ~aboveRef;
      OP_INSIDE:  hit = edgesOk & inRange;
      OP_OUTSIDE: hit = edgesOk & ~inRange;
      default:    hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/tmu_control.sv
module tmu_control
  import tmu_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter bit CNT_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hit,
  input  logic             rearm,
  input  logic [CNT_W-1:0] cfgCount,
  output tmu_strobe_t      strobe,
  output logic             matchEvent
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic edgeValidQ;
  logic eventQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeValidQ <= 1'b0;
    else       edgeValidQ <= 1'b1;
  end

  assign strobe.edgeValid = edgeValidQ;
  assign strobe.sampleEn  = 1'b1;

  if (CNT_EN) begin : g_counter
    logic [CNT_W-1:0] cntQ;
    logic [CNT_W-1:0] target;
    logic [CNT_W:0]   nextCount;
    logic             reached;

    assign target    = (cfgCount == '0) ? CNT_W'(1) : cfgCount;
    assign nextCount = {1'b0, cntQ} + 1'b1;
    assign reached   = nextCount >= {1'b0, target};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ   <= '0;
        eventQ <= 1'b0;
      end else if (rearm) begin
        cntQ   <= '0;
        eventQ <= 1'b0;
      end else begin
        eventQ <= hit & reached;
        if (hit && cntQ != CNT_MAX) cntQ <= cntQ + 1'b1;
      end
    end
  end else begin : g_direct
    logic unusedCount;
    assign unusedCount = ^cfgCount;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) eventQ <= 1'b0;
      else       eventQ <= hit & ~rearm;
    end
  end

  assign matchEvent = eventQ;

endmodule

// File: rtl/trig_match_unit.sv
module trig_match_unit
  import tmu_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int CNT_W  = 4,
  parameter bit CNT_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WIDTH-1:0]   trigIn,
  input  logic [3*WIDTH-1:0] cfgBitMode,
  input  logic [2:0]         cfgOp,
  input  logic [WIDTH-1:0]   cfgLow,
  input  logic [WIDTH-1:0]   cfgHigh,
  input  logic [CNT_W-1:0]   cfgCount,
  input  logic               rearm,
  output logic               matchEvent
);

  tmu_strobe_t strobe;
  logic        dpHit;

  tmu_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .trigIn     (trigIn),
    .cfgBitMode (cfgBitMode),
    .cfgOp      (cfgOp),
    .cfgLow     (cfgLow),
    .cfgHigh    (cfgHigh),
    .hit        (dpHit)
  );

  tmu_control #(.CNT_W(CNT_W), .CNT_EN(CNT_EN)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hit        (dpHit),
    .rearm      (rearm),
    .cfgCount   (cfgCount),
    .strobe     (strobe),
    .matchEvent (matchEvent)
  );

endmodule

// File: rtl/tmu_checker.sv
module tmu_checker #(
  parameter int CNT_W  = 4,
  parameter bit CNT_EN = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic             rearm,
  input logic [CNT_W-1:0] cfgCount,
  input logic             dpHit,
  input logic             matchEvent
);

  localparam logic [CNT_W-1:0] SEEN_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] seenQ;
  logic [CNT_W-1:0] effTarget;

  assign effTarget = (cfgCount == '0) ? CNT_W'(1) : cfgCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          seenQ <= '0;
    else if (rearm)                     seenQ <= '0;
    else if (dpHit && seenQ != SEEN_MAX) seenQ <= seenQ + 1'b1;
  end

  // R1
  always @(posedge clk) begin
    if (!rstN) reset_quiet_chk: assert (!matchEvent);
  end

  // R9
  rearm_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    rearm |=> !matchEvent);

  // R7
  event_from_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchEvent |-> $past(dpHit));

  // R8
  count_reached_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchEvent && CNT_EN) |-> (seenQ >= $past(effTarget)));

endmodule

bind trig_match_unit tmu_checker #(.CNT_W(CNT_W), .CNT_EN(CNT_EN)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rearm      (rearm),
  .cfgCount   (cfgCount),
  .dpHit      (dpHit),
  .matchEvent (matchEvent)
);

// File: tb/tb_trig_match_unit.sv
`timescale 1ns/1ps
module tb_trig_match_unit;

  localparam int W  = 8;
  localparam int CW = 4;

  logic            clk = 1'b0;
  logic            rstN;
  logic [W-1:0]    trigIn;
  logic [3*W-1:0]  cfgBitMode;
  logic [2:0]      cfgOp;
  logic [W-1:0]    cfgLow;
  logic [W-1:0]    cfgHigh;
  logic [CW-1:0]   cfgCount;
  logic            rearm;
  logic            matchEvent;

  int checks = 0;
  int fails  = 0;

  // model state
  logic [W-1:0]  mPrev;
  logic          mValid;
  logic [CW-1:0] mCnt;
  logic          lastExp;

  always #10 clk = ~clk;

  trig_match_unit #(.WIDTH(W), .CNT_W(CW), .CNT_EN(1'b1)) dut (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .cfgBitMode(cfgBitMode),
    .cfgOp(cfgOp), .cfgLow(cfgLow), .cfgHigh(cfgHigh), .cfgCount(cfgCount),
    .rearm(rearm), .matchEvent(matchEvent)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: matchEvent=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference comparison from the requirements (R2..R6)
  function automatic logic hitModel(input logic [W-1:0] cur, input logic [W-1:0] prv,
                                    input logic pv, input logic [3*W-1:0] modes,
                                    input logic [2:0] op, input logic [W-1:0] lo,
                                    input logic [W-1:0] hi);
    logic [W-1:0] mask = '0;
    logic [W-1:0] refv = '0;
    logic         eok  = 1'b1;
    logic [W-1:0] c, l, h;
    logic         eq;
    for (int i = 0; i < W; i++) begin
      logic [2:0] m = modes[3*i +: 3];
      case (m)
        3'd0: mask[i] = 1'b1;
        3'd1: begin mask[i] = 1'b1; refv[i] = 1'b1; end
        3'd3: if (!(pv && !prv[i] && cur[i])) eok = 1'b0;
        3'd4: if (!(pv && prv[i] && !cur[i])) eok = 1'b0;
        3'd5: if (!(pv && (prv[i] != cur[i]))) eok = 1'b0;
        3'd6: if (pv && (prv[i] != cur[i])) eok = 1'b0;
        default: ;
      endcase
    end
    c = cur & mask; l = lo & mask; h = hi & mask;
    eq = (c == refv);
    case (op)
      3'd0: return eok && eq;
      3'd1: return !(eok && eq);
      3'd2: return eok && (c > refv);
      3'd3: return eok && (c >= refv);
      3'd4: return eok && (c < refv);
      3'd5: return eok && (c <= refv);
      3'd6: return eok && (c >= l) && (c <= h);
      default: return eok && !((c >= l) && (c <= h));
    endcase
  endfunction

  function automatic logic [3*W-1:0] allModes(input logic [2:0] m);
    logic [3*W-1:0] r;
    for (int i = 0; i < W; i++) r[3*i +: 3] = m;
    return r;
  endfunction

  function automatic logic [3*W-1:0] levelModes(input logic [W-1:0] v);
    logic [3*W-1:0] r;
    for (int i = 0; i < W; i++) r[3*i +: 3] = v[i] ? 3'd1 : 3'd0;
    return r;
  endfunction

  function automatic logic [3*W-1:0] setMode(input logic [3*W-1:0] base,
                                             input int idx, input logic [2:0] m);
    logic [3*W-1:0] r = base;
    r[3*idx +: 3] = m;
    return r;
  endfunction

  // Called just after a falling edge: drive, check hold (R7), clock, check result.
  task automatic step(input logic [W-1:0] t, input logic [3*W-1:0] modes,
                      input logic [2:0] op, input logic [W-1:0] lo, input logic [W-1:0] hi,
                      input logic [CW-1:0] cnt, input logic ra, input string tag);
    logic h, exp;
    logic [CW:0] nxt;
    logic [CW-1:0] tgt;
    trigIn = t; cfgBitMode = modes; cfgOp = op; cfgLow = lo; cfgHigh = hi;
    cfgCount = cnt; rearm = ra;
    h   = hitModel(t, mPrev, mValid, modes, op, lo, hi);
    tgt = (cnt == 0) ? CW'(1) : cnt;
    nxt = {1'b0, mCnt} + 1'b1;
    if (ra) begin
      exp = 1'b0; mCnt = '0;
    end else begin
      exp = h && (nxt >= {1'b0, tgt});
      if (h && mCnt != {CW{1'b1}}) mCnt = mCnt + 1'b1;
    end
    mPrev = t; mValid = 1'b1;
    #2;
    check("R7 hold", matchEvent, lastExp);
    @(posedge clk);
    @(negedge clk);
    check(tag, matchEvent, exp);
    lastExp = exp;
  endtask

  task automatic doReset();
    rstN = 1'b0; rearm = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R1 reset", matchEvent, 1'b0);
    mValid = 1'b0; mCnt = '0; lastExp = 1'b0;
    rstN = 1'b1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    logic [3*W-1:0] dc;
    logic [3*W-1:0] lv;
    void'($urandom(32'd4242));
    dc = allModes(3'd2);
    trigIn = 8'h5A; cfgBitMode = dc; cfgOp = 3'd0; cfgLow = '0; cfgHigh = '0;
    cfgCount = '0; rearm = 1'b0; rstN = 1'b0; mPrev = '0;
    doReset();
    // R1: first sample after reset: steady passes even though bus changed
    step(8'h00, allModes(3'd6), 3'd0, 0, 0, 0, 0, "R1 steady first");
    // R3 edges on bit 0 / bit 7
    step(8'h01, setMode(dc, 0, 3'd3), 3'd0, 0, 0, 0, 0, "R3 rise");
    step(8'h00, setMode(dc, 0, 3'd4), 3'd0, 0, 0, 0, 0, "R3 fall");
    step(8'h00, setMode(dc, 0, 3'd3), 3'd0, 0, 0, 0, 0, "R3 no rise");
    step(8'h00, setMode(dc, 0, 3'd6), 3'd0, 0, 0, 0, 0, "R3 steady");
    step(8'h80, setMode(dc, 7, 3'd5), 3'd0, 0, 0, 0, 0, "R3 any");
    step(8'h80, setMode(dc, 7, 3'd5), 3'd0, 0, 0, 0, 0, "R3 any none");
    // R2 levels and don't care
    lv = levelModes(8'hA5);
    step(8'hA5, lv, 3'd0, 0, 0, 0, 0, "R2 eq hit");
    step(8'hA4, lv, 3'd0, 0, 0, 0, 0, "R2 eq miss");
    step(8'hA4, setMode(lv, 0, 3'd7), 3'd0, 0, 0, 0, 0, "R2 dc bit");
    // R4
    step(8'hA5, lv, 3'd1, 0, 0, 0, 0, "R4 ne eq");
    step(8'h25, lv, 3'd1, 0, 0, 0, 0, "R4 ne diff");
    // R5 magnitude vs 0x40
    lv = levelModes(8'h40);
    step(8'h41, lv, 3'd2, 0, 0, 0, 0, "R5 gt");
    step(8'h40, lv, 3'd2, 0, 0, 0, 0, "R5 gt equal");
    step(8'h40, lv, 3'd3, 0, 0, 0, 0, "R5 ge");
    step(8'h3F, lv, 3'd4, 0, 0, 0, 0, "R5 lt");
    step(8'h40, lv, 3'd5, 0, 0, 0, 0, "R5 le");
    step(8'hC0, setMode(lv, 7, 3'd2), 3'd2, 0, 0, 0, 0, "R5 masked gt");
    // R6 range 0x10..0x20
    lv = allModes(3'd0);
    step(8'h10, lv, 3'd6, 8'h10, 8'h20, 0, 0, "R6 low bound");
    step(8'h20, lv, 3'd6, 8'h10, 8'h20, 0, 0, "R6 high bound");
    step(8'h21, lv, 3'd6, 8'h10, 8'h20, 0, 0, "R6 above");
    step(8'h21, lv, 3'd7, 8'h10, 8'h20, 0, 0, "R6 outside");
    step(8'h0F, lv, 3'd7, 8'h10, 8'h20, 0, 0, "R6 outside low");
    // R8 / R9 counting with always-true compare
    step(8'h00, dc, 3'd0, 0, 0, 3, 1, "R9 rearm");
    step(8'h00, dc, 3'd0, 0, 0, 3, 0, "R8 count1");
    step(8'h00, dc, 3'd0, 0, 0, 3, 0, "R8 count2");
    step(8'h00, dc, 3'd0, 0, 0, 3, 0, "R8 count3");
    step(8'h00, dc, 3'd0, 0, 0, 3, 0, "R8 beyond");
    step(8'h00, dc, 3'd0, 0, 0, 3, 1, "R9 rearm clears");
    step(8'h00, dc, 3'd0, 0, 0, 3, 0, "R9 after rearm");
    for (int k = 0; k < 20; k++) step(8'h00, dc, 3'd0, 0, 0, 4'hF, 0, "R8 saturate");
    step(8'h00, dc, 3'd0, 0, 0, 0, 1, "R9 rearm");
    step(8'h00, dc, 3'd0, 0, 0, 0, 0, "R8 target zero");
    // R1 again: any-transition fails on first sample
    doReset();
    step(8'hFF, allModes(3'd5), 3'd0, 0, 0, 0, 0, "R1 any first");
    // random
    for (int k = 0; k < 3000; k++) begin
      logic [3*W-1:0] m;
      logic [W-1:0]   t;
      logic [2:0]     op;
      string          tag;
      for (int i = 0; i < W; i++) begin
        int r = $urandom % 10;
        m[3*i +: 3] = (r < 5) ? 3'd2 : (r == 5) ? 3'd0 : (r == 6) ? 3'd1
                    : 3'(3 + $urandom % 4);
      end
      t  = ($urandom % 4 == 0) ? mPrev : W'($urandom);
      op = 3'($urandom);
      case (op)
        3'd0:          tag = "R2 rand";
        3'd1:          tag = "R4 rand";
        3'd6, 3'd7:    tag = "R6 rand";
        default:       tag = "R5 rand";
      endcase
      step(t, m, op, W'($urandom), W'($urandom), CW'($urandom % 5),
           ($urandom % 16 == 0), {tag, " R3 R8 R9"});
    end
    summary();
    $finish;
  end

endmodule